// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is a row of boundary-scan cells placed between the device pins and the core logic. Each cell has two storage stages. The first is a capture/shift stage. It can load the value at the cell's parallel input, or take the bit arriving from the previous cell so that the whole row acts as one serial shift register from `tdi` to `tdo`. The second is an update stage. It takes a copy of the capture/shift stage when the test controller asks for one, and it holds that copy steady while new data shifts through.

A mode code is decoded once and shared by all cells.

- In the pass-through modes, each `pin_out` bit follows its `pin_in` bit directly, so the functional path keeps running while pin values are sampled.
- In the drive modes, each `pin_out` bit is taken from the update stage. This supports testing the board interconnect, applying vectors to the core, and holding outputs at fixed values.

The capture and update strobes are single-cycle enables on the test clock `clk`. A TAP controller outside this block generates them.

All pins are plain control and data pins. The serial path has no valid/ready handshake, because the controller owns every shift cycle and there is no back-pressure on the serial path.

Top module: `bscan_chain`

## Requirements
- R1: While `rst_n` is low, both stages of every cell are zero, so `tdo` reads 0 and `pin_out` reads 0 in a drive mode.
- R2: A clock edge with `cap_en`=1 and `shift_sel`=0 loads every capture stage from its `pin_in` bit.
- R3: A clock edge with `cap_en`=1 and `shift_sel`=1 moves the chain one place. Cell 0 takes `tdi`, cell k takes cell k-1, and `tdo` shows cell N-1. The bit shifted in first therefore reaches `tdo` first after N shifts.
- R4: A clock edge with `cap_en`=0 leaves every capture stage unchanged.
- R5: A clock edge with `upd_en`=1 and `cap_en`=0 copies each capture stage into its update stage.
- R6: `upd_en` is ignored on any edge where `cap_en`=1, so the update stage and the driven outputs stay stable while data shifts or is captured.
- R7: `mode` codes 0 (normal) and 1 (sample) make `pin_out` equal `pin_in` in the same cycle.
- R8: `mode` codes 2 (external test), 3 (internal test) and 4 (clamp) make `pin_out` equal the update stage.
- R9: Unused `mode` codes 5, 6 and 7 behave as normal (pass-through).
- R10: In sample mode, a capture stores the live `pin_in` values while `pin_out` keeps following `pin_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_en | input | 1 | Capture/shift strobe for one edge |
| shift_sel | input | 1 | 1 selects shifting, 0 selects parallel capture |
| upd_en | input | 1 | Update strobe for one edge |
| mode | input | 3 | Mode code (see R7 to R9) |
| tdi | input | 1 | Serial input to cell 0 |
| pin_in | input | NCELLS | Parallel values from pins or core |
| pin_out | output | NCELLS | Values toward core or pins |
| tdo | output | 1 | Serial output from the last cell |

## Verification
Capture, shift and update results appear after the single rising edge at which the strobe is sampled. `pin_out` responds to `mode` and `pin_in` combinationally, in the same cycle. The bench changes inputs at the falling edge and reads results at the following falling edge, or a nanosecond after a combinational change. While shifting, `tdo` is read at each falling edge before the next shift edge, so the word comes out most significant bit first. Stage contents that cannot be seen directly are brought out through the chain with a shift, or onto `pin_out` with an update in a drive mode.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [2:0] {
    BS_NORMAL = 3'd0,
    BS_SAMPLE = 3'd1,
    BS_EXTEST = 3'd2,
    BS_INTEST = 3'd3,
    BS_CLAMP  = 3'd4
  } bs_mode_e;
endpackage

// File: rtl/bscan_mode_dec.sv
module bscan_mode_dec
  import bscan_pkg::*;
(
  input  logic [2:0] mode_raw,
  output logic       drive_test
);
  always_comb begin
    case (mode_raw)
      BS_EXTEST, BS_INTEST, BS_CLAMP: drive_test = 1'b1;
      default:                        drive_test = 1'b0;
    endcase
  end
endmodule

// File: rtl/bscan_cell.sv
module bscan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shift_sel,
  input  logic upd_en,
  input  logic drive_test,
  input  logic pin_in,
  input  logic scan_in,
  output logic scan_out,
  output logic pin_out
);
  logic cap_q;
  logic upd_q;
  logic upd_take;

  // Update is blocked while a capture or shift edge is in progress
  assign upd_take = upd_en & ~cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= 1'b0;
    else if (cap_en) cap_q <= shift_sel ? scan_in : pin_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        upd_q <= 1'b0;
    else if (upd_take) upd_q <= cap_q;
  end

  assign scan_out = cap_q;
  assign pin_out  = drive_test ? upd_q : pin_in;

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !shift_sel) |=> (scan_out == $past(pin_in)));
  a_r3_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && shift_sel) |=> (scan_out == $past(scan_in)));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(scan_out));
  a_r5_update: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !cap_en) |=> (upd_q == $past(scan_out)));
  a_r6_stable_shift: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> $stable(upd_q));
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int NCELLS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              shift_sel,
  input  logic              upd_en,
  input  logic [2:0]        mode,
  input  logic              tdi,
  input  logic [NCELLS-1:0] pin_in,
  output logic [NCELLS-1:0] pin_out,
  output logic              tdo
);
  localparam int LINKS = NCELLS + 1;

  logic [LINKS-1:0] link;
  logic             drive_test;

  bscan_mode_dec u_dec (
    .mode_raw   (mode),
    .drive_test (drive_test)
  );

  assign link[0] = tdi;

  for (genvar k = 0; k < NCELLS; k++) begin : g_cell
    bscan_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_en     (cap_en),
      .shift_sel  (shift_sel),
      .upd_en     (upd_en),
      .drive_test (drive_test),
      .pin_in     (pin_in[k]),
      .scan_in    (link[k]),
      .scan_out   (link[k+1]),
      .pin_out    (pin_out[k])
    );
  end

  assign tdo = link[NCELLS];

  // R7/R9: outside drive modes the output is the pin value
  a_r7_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (mode < 3'd2 || mode > 3'd4) |-> (pin_out == pin_in));
  // R8: in drive modes outputs change only on an update edge
  a_r8_drive_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode inside {3'd2, 3'd3, 3'd4} && $stable(mode) && !$past(upd_en))
      |-> $stable(pin_out));
endmodule

// File: tb/bscan_chain_test.sv
`timescale 1ns/1ps
module bscan_chain_test;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap_en = 1'b0, shift_sel = 1'b0, upd_en = 1'b0, tdi = 1'b0;
  logic [2:0] mode = 3'd2;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out;
  logic tdo;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bscan_chain #(.NCELLS(N)) uut (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .shift_sel(shift_sel),
    .upd_en(upd_en), .mode(mode), .tdi(tdi), .pin_in(pin_in),
    .pin_out(pin_out), .tdo(tdo)
  );

  // {mode, pin_in, expected pin_out} with update stage holding 8'hA5
  localparam logic [18:0] VEC [0:7] = '{
    {3'd0, 8'h3C, 8'h3C}, {3'd1, 8'h5A, 8'h5A},
    {3'd2, 8'hFF, 8'hA5}, {3'd3, 8'h00, 8'hA5},
    {3'd4, 8'h81, 8'hA5}, {3'd5, 8'h12, 8'h12},
    {3'd6, 8'h34, 8'h34}, {3'd7, 8'hC3, 8'hC3}
  };

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic shift_word(input logic [N-1:0] din, output logic [N-1:0] dout);
    for (int i = N - 1; i >= 0; i--) begin
      @(negedge clk);
      dout[i] = tdo;
      tdi = din[i]; cap_en = 1'b1; shift_sel = 1'b1;
    end
    @(negedge clk);
    cap_en = 1'b0; shift_sel = 1'b0;
  endtask

  task automatic pulse_update();
    @(negedge clk); upd_en = 1'b1;
    @(negedge clk); upd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [N-1:0] got;
    string tag;

    // R1: reset state, including a strobe applied during reset
    cap_en = 1'b1; upd_en = 1'b1; pin_in = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 pin_out in reset", pin_out, 8'h00);
    chk("R1 tdo in reset", {7'd0, tdo}, 8'h00);
    cap_en = 1'b0; upd_en = 1'b0; pin_in = 8'h00;
    rst_n = 1'b1;

    // R3 / R1: shift A5 in; the bits coming out are the cleared stages
    shift_word(8'hA5, got);
    chk("R1 cleared chain out", got, 8'h00);
    chk("R8 no update yet", pin_out, 8'h00);
    pulse_update();
    chk("R5 update copies A5", pin_out, 8'hA5);

    // Table walk over modes (R7, R8, R9)
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      mode = VEC[v][18:16]; pin_in = VEC[v][15:8];
      #1;
      tag = (VEC[v][18:16] < 3'd2) ? "R7 mode mux" :
            (VEC[v][18:16] > 3'd4) ? "R9 unused mode" : "R8 drive mode";
      chk(tag, pin_out, VEC[v][7:0]);
    end

    // R6: shift while update strobe held high; outputs must not move
    @(negedge clk); mode = 3'd2;
    shift_word(8'h0F, got);
    chk("R3 shifted out A5", got, 8'hA5);
    chk("R6 hold during shift", pin_out, 8'hA5);
    @(negedge clk);
    cap_en = 1'b1; shift_sel = 1'b1; upd_en = 1'b1; tdi = 1'b1;
    @(negedge clk);
    cap_en = 1'b0; shift_sel = 1'b0; upd_en = 1'b0;
    chk("R6 update ignored with cap_en", pin_out, 8'hA5);
    pulse_update();
    chk("R5 update after extra shift", pin_out, 8'h1F);

    // R2 / R4: parallel capture, then idle with changing pins
    @(negedge clk); mode = 3'd0; pin_in = 8'hC6;
    cap_en = 1'b1; shift_sel = 1'b0;
    @(negedge clk); cap_en = 1'b0; pin_in = 8'h39;
    repeat (3) @(negedge clk);
    shift_word(8'h00, got);
    chk("R2 R4 captured C6 held", got, 8'hC6);

    // R10: sample mode capture with live pass-through
    @(negedge clk); mode = 3'd1; pin_in = 8'h3C;
    cap_en = 1'b1; shift_sel = 1'b0;
    #1 chk("R10 pass-through during capture", pin_out, 8'h3C);
    @(negedge clk); cap_en = 1'b0;
    chk("R10 pass-through after capture", pin_out, 8'h3C);
    shift_word(8'h00, got);
    chk("R10 sampled value", got, 8'h3C);

    // R8: clamp drives last update (1F) regardless of pins
    @(negedge clk); mode = 3'd4; pin_in = 8'hE7;
    #1 chk("R8 clamp", pin_out, 8'h1F);

    finish_run();
  end
endmodule